// File: doc/BRIEF.md
# Dynamic Address Assignment Responder

This block sequences the controller side of the broadcast address-assignment procedure on an I3C bus. After software starts a run, the bit-level engine reports the identification bytes of each target that wins arbitration. The responder stores these bytes in a receive byte queue. After the sixth byte of a target it raises a request flag, which can drive an interrupt, and it holds the engine before the address phase.

Software reads the six bytes and pushes a 7-bit dynamic address into a small transmit queue. The responder turns that address into the on-bus byte, with the address in bits [7:1] and an odd-parity bit in bit 0. It offers the byte to the engine with a valid/ready handshake and counts each address handed over. A run normally ends when no target acknowledges. The engine then reports a response code, and the responder treats code 6 (no acknowledge) or code 4 (protocol error class 2) as a clean finish.

Top module: `daa_responder`

## Requirements
- R1: After reset the block is idle. busy_o, daa_pend_o, irq_o, addr_valid_o and done_o are 0, assigned_o is 0 and rx_empty_o is 1.
- R2: While a run is collecting, each byte accepted on id_byte_i is stored in the receive queue. Software reads the bytes in arrival order: rx_data_o shows the oldest byte, and rx_pop_i removes it.
- R3: The request flag daa_pend_o sets on the clock edge that accepts the sixth identification byte of a target, and not before. irq_o equals daa_pend_o while irq_mask_i is 1 and is 0 while irq_mask_i is 0.
- R4: irq_clr_i clears daa_pend_o on the next edge (write-one-to-clear). If a new request arrives in the same cycle as a clear, the flag ends up set.
- R5: After a request, addr_valid_o stays 0 until the transmit queue holds an address. While addr_ready_i is 0, addr_valid_o stays 1 and addr_byte_o stays stable. addr_valid_o is never 1 while the block is idle.
- R6: addr_byte_o is {address[6:0], p}, where p is 1 when the address has an even number of ones. The whole byte therefore has odd parity.
- R7: assigned_o counts the address bytes the engine has taken in the current run. It increments once per handshake and returns to 0 on daa_start_i.
- R8: Identification bytes that arrive while idle, or while waiting for software's address, are dropped. They do not reach the receive queue and raise no request.
- R9: A response in an active run ends the run. done_o pulses for one cycle and busy_o returns to 0. done_err_o is 0 for codes 6 and 4 and is 1 for any other code.
- R10: Once MAX_TARGETS addresses have been handed off, assigned_o stops at MAX_TARGETS. Later identification bytes are dropped and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| daa_start_i | input | 1 | Starts a run and clears the counter |
| id_valid_i | input | 1 | Identification byte strobe from the engine |
| id_byte_i | input | 8 | Identification byte |
| resp_valid_i | input | 1 | Engine reports the end of the procedure |
| resp_code_i | input | 4 | Response code of the procedure |
| addr_ready_i | input | 1 | Engine takes the address byte |
| addr_valid_o | output | 1 | Address byte offered to the engine |
| addr_byte_o | output | 8 | Address with parity bit in bit 0 |
| tx_push_i | input | 1 | Software pushes an address |
| tx_addr_i | input | 7 | 7-bit dynamic address |
| rx_pop_i | input | 1 | Software removes the oldest identification byte |
| rx_data_o | output | 8 | Oldest identification byte |
| rx_empty_o | output | 1 | Receive queue empty |
| irq_mask_i | input | 1 | Request interrupt enable |
| irq_clr_i | input | 1 | Write-one-to-clear of the request flag |
| daa_pend_o | output | 1 | Request flag |
| irq_o | output | 1 | Masked request interrupt |
| assigned_o | output | 5 | Addresses assigned in this run |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| done_err_o | output | 1 | Run ended with an unexpected code |
| busy_o | output | 1 | A run is in progress |

## Verification
The assertions check properties that must hold in every cycle:
- the odd parity of every offered address byte;
- that an offer stays put while the engine stalls, and that nothing is offered while idle;
- that the request flag rises only on an accepted identification byte, and that it clears one edge after irq_clr_i;
- that the counter resets on start, steps only on a handshake and never passes MAX_TARGETS;
- that done_o is a single-cycle pulse.

Other behaviour needs the bench's scenarios:
- the sixth-byte timing of the request;
- the order of bytes in the receive queue;
- that stray bytes are dropped;
- the ok/error split of the response codes;
- the behaviour after a full set of sixteen targets.

// File: rtl/daa_pkg.sv
package daa_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_WAIT_SW, ST_FULL} daa_state_e;

  localparam int unsigned ID_BYTES = 6;
  localparam logic [3:0] RESP_NACK = 4'd6;
  localparam logic [3:0] RESP_CE2  = 4'd4;

  // odd parity over the whole byte
  function automatic logic [7:0] daa_format(input logic [6:0] addr);
    return {addr, ~^addr};
  endfunction
endpackage

// File: rtl/daa_byte_fifo.sv
module daa_byte_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/daa_irq_flag.sv
module daa_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & mask_i;
endmodule

// File: rtl/daa_seq.sv
module daa_seq
  import daa_pkg::*;
#(
  parameter int unsigned MAX_TARGETS = 16,
  parameter int unsigned CNT_W = $clog2(MAX_TARGETS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             id_valid_i,
  input  logic             resp_valid_i,
  input  logic [3:0]       resp_code_i,
  input  logic             tx_avail_i,
  input  logic             addr_ready_i,
  output logic             id_take_o,
  output logic             req_o,
  output logic             addr_valid_o,
  output logic             addr_take_o,
  output logic [CNT_W-1:0] assigned_o,
  output logic             done_o,
  output logic             done_err_o,
  output logic             busy_o
);
  localparam int unsigned ID_W = $clog2(ID_BYTES);

  daa_state_e       state_q, state_d;
  logic [ID_W-1:0]  byte_q, byte_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d, err_q, err_d;

  always_comb begin
    state_d      = state_q;
    byte_d       = byte_q;
    cnt_d        = cnt_q;
    done_d       = 1'b0;
    err_d        = 1'b0;
    id_take_o    = 1'b0;
    req_o        = 1'b0;
    addr_take_o  = 1'b0;
    addr_valid_o = (state_q == ST_WAIT_SW) && tx_avail_i && !start_i;
    if (start_i) begin
      state_d = ST_COLLECT;
      byte_d  = '0;
      cnt_d   = '0;
    end else begin
      if (addr_valid_o && addr_ready_i) begin
        addr_take_o = 1'b1;
        cnt_d       = cnt_q + 1'b1;
        state_d     = (cnt_q == CNT_W'(MAX_TARGETS - 1)) ? ST_FULL : ST_COLLECT;
      end
      if (state_q == ST_COLLECT && id_valid_i && !resp_valid_i) begin
        id_take_o = 1'b1;
        if (byte_q == ID_W'(ID_BYTES - 1)) begin
          byte_d  = '0;
          state_d = ST_WAIT_SW;
          req_o   = 1'b1;
        end else begin
          byte_d = byte_q + 1'b1;
        end
      end
      if (resp_valid_i && state_q != ST_IDLE) begin
        state_d = ST_IDLE;
        byte_d  = '0;
        done_d  = 1'b1;
        err_d   = !(resp_code_i == RESP_NACK || resp_code_i == RESP_CE2);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign assigned_o = cnt_q;
  assign done_o     = done_q;
  assign done_err_o = err_q;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/daa_responder.sv
module daa_responder
  import daa_pkg::*;
#(
  parameter int unsigned MAX_TARGETS = 16,
  parameter int unsigned RX_DEPTH    = 8,
  parameter int unsigned TX_DEPTH    = 2,
  localparam int unsigned CNT_W      = $clog2(MAX_TARGETS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             daa_start_i,
  input  logic             id_valid_i,
  input  logic [7:0]       id_byte_i,
  input  logic             resp_valid_i,
  input  logic [3:0]       resp_code_i,
  input  logic             addr_ready_i,
  output logic             addr_valid_o,
  output logic [7:0]       addr_byte_o,
  input  logic             tx_push_i,
  input  logic [6:0]       tx_addr_i,
  input  logic             rx_pop_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_empty_o,
  input  logic             irq_mask_i,
  input  logic             irq_clr_i,
  output logic             daa_pend_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] assigned_o,
  output logic             done_o,
  output logic             done_err_o,
  output logic             busy_o
);
  logic       id_take, req, addr_take, tx_empty;
  logic [6:0] tx_head;

  daa_byte_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (id_take),
    .data_i (id_byte_i),
    .pop_i  (rx_pop_i),
    .data_o (rx_data_o),
    .empty_o(rx_empty_o)
  );

  daa_byte_fifo #(.WIDTH(7), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_push_i),
    .data_i (tx_addr_i),
    .pop_i  (addr_take),
    .data_o (tx_head),
    .empty_o(tx_empty)
  );

  daa_seq #(.MAX_TARGETS(MAX_TARGETS), .CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni,
    .start_i     (daa_start_i),
    .id_valid_i  (id_valid_i),
    .resp_valid_i(resp_valid_i),
    .resp_code_i (resp_code_i),
    .tx_avail_i  (!tx_empty),
    .addr_ready_i(addr_ready_i),
    .id_take_o   (id_take),
    .req_o       (req),
    .addr_valid_o(addr_valid_o),
    .addr_take_o (addr_take),
    .assigned_o  (assigned_o),
    .done_o      (done_o),
    .done_err_o  (done_err_o),
    .busy_o      (busy_o)
  );

  daa_irq_flag i_irq (
    .clk_i, .rst_ni,
    .set_i (req),
    .clr_i (irq_clr_i),
    .mask_i(irq_mask_i),
    .pend_o(daa_pend_o),
    .irq_o (irq_o)
  );

  assign addr_byte_o = daa_format(tx_head);
endmodule

// File: rtl/daa_responder_chk.sv
module daa_responder_chk #(
  parameter int unsigned MAX_TARGETS = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             daa_start_i,
  input logic             id_valid_i,
  input logic             resp_valid_i,
  input logic             addr_ready_i,
  input logic             irq_clr_i,
  input logic             addr_valid_o,
  input logic [7:0]       addr_byte_o,
  input logic             daa_pend_o,
  input logic [CNT_W-1:0] assigned_o,
  input logic             done_o,
  input logic             busy_o
);
  AST_ADDR_ODD_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> (^addr_byte_o)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i && !daa_start_i && !resp_valid_i
    |=> daa_start_i || (addr_valid_o && $stable(addr_byte_o))); // R5
  AST_IDLE_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !addr_valid_o); // R5
  AST_PEND_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(daa_pend_o) |-> $past(id_valid_i)); // R3
  AST_PEND_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(irq_clr_i) && !$past(id_valid_i) |-> !daa_pend_o); // R4
  AST_COUNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(daa_start_i) |-> assigned_o == '0); // R7
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(daa_start_i) && assigned_o != $past(assigned_o)
    |-> $past(addr_valid_o && addr_ready_i)); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    assigned_o <= CNT_W'(MAX_TARGETS)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
endmodule

bind daa_responder daa_responder_chk #(.MAX_TARGETS(MAX_TARGETS), .CNT_W(CNT_W)) i_chk (
  .clk_i, .rst_ni, .daa_start_i, .id_valid_i, .resp_valid_i, .addr_ready_i,
  .irq_clr_i, .addr_valid_o, .addr_byte_o, .daa_pend_o, .assigned_o, .done_o, .busy_o
);

// File: tb/test_daa_responder.sv
module test_daa_responder;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       daa_start_i = 0, id_valid_i = 0, resp_valid_i = 0, addr_ready_i = 1;
  logic [7:0] id_byte_i = '0;
  logic [3:0] resp_code_i = '0;
  logic       tx_push_i = 0, rx_pop_i = 0, irq_mask_i = 1, irq_clr_i = 0;
  logic [6:0] tx_addr_i = '0;
  logic       addr_valid_o, rx_empty_o, daa_pend_o, irq_o, done_o, done_err_o, busy_o;
  logic [7:0] addr_byte_o, rx_data_o;
  logic [4:0] assigned_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_addr_q[$];
  logic [7:0] exp_rx_q[$];

  always #10 clk_i = ~clk_i;

  daa_responder i_daa_responder (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fmt(input logic [6:0] a);
    int ones = 0;
    for (int i = 0; i < 7; i++) ones += a[i];
    return {a, (ones % 2 == 0) ? 1'b1 : 1'b0};
  endfunction

  task automatic tick();
    @(posedge clk_i); #2;
  endtask

  // monitor: scoreboard of address handshakes
  initial forever begin
    @(negedge clk_i);
    if (rst_ni && addr_valid_o && addr_ready_i) begin
      if (exp_addr_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 act=%0h exp=none", addr_byte_o);
      end else chk("R6 addr byte", addr_byte_o, exp_addr_q.pop_front());
    end
  end

  task automatic send_id(input logic [7:0] b, input bit stored, input bit clr = 0);
    tick(); id_valid_i = 1; id_byte_i = b; irq_clr_i = clr;
    if (stored) exp_rx_q.push_back(b);
    tick(); id_valid_i = 0; irq_clr_i = 0;
  endtask

  task automatic send_target(input logic [7:0] base);
    for (int i = 0; i < 6; i++) send_id(base + 8'(i), 1);
  endtask

  task automatic drain_rx();
    while (exp_rx_q.size() != 0) begin
      chk("R2 rx order", rx_data_o, exp_rx_q.pop_front());
      tick(); rx_pop_i = 1; tick(); rx_pop_i = 0;
    end
    chk("R8 rx empty", rx_empty_o, 1);
  endtask

  task automatic push_addr(input logic [6:0] a);
    exp_addr_q.push_back(fmt(a));
    tick(); tx_push_i = 1; tx_addr_i = a; tick(); tx_push_i = 0;
  endtask

  task automatic start();
    tick(); daa_start_i = 1; tick(); daa_start_i = 0;
  endtask

  task automatic clear_pend();
    tick(); irq_clr_i = 1; tick(); irq_clr_i = 0;
  endtask

  task automatic end_run(input logic [3:0] code, input logic err);
    tick(); resp_valid_i = 1; resp_code_i = code; tick(); resp_valid_i = 0;
    chk("R9 done pulse", done_o, 1);
    chk("R9 done err", done_err_o, err);
    tick();
    chk("R9 done low", done_o, 0);
    chk("R9 idle", busy_o, 0);
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    tick();
    chk("R1 busy", busy_o, 0);
    chk("R1 pend", daa_pend_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 addr_valid", addr_valid_o, 0);
    chk("R1 assigned", assigned_o, 0);
    chk("R1 rx_empty", rx_empty_o, 1);
    chk("R1 done", done_o, 0);

    send_id(8'hEE, 0);
    chk("R8 idle byte dropped", rx_empty_o, 1);
    chk("R8 idle no request", daa_pend_o, 0);

    start();
    chk("R7 busy after start", busy_o, 1);
    for (int i = 0; i < 5; i++) send_id(8'hA0 + 8'(i), 1);
    chk("R3 no request before sixth", daa_pend_o, 0);
    send_id(8'hA5, 1, 1);
    chk("R4 set wins over clear", daa_pend_o, 1);
    chk("R3 irq raised", irq_o, 1);
    irq_mask_i = 0; #1;
    chk("R3 irq masked", irq_o, 0);
    irq_mask_i = 1;
    send_id(8'h77, 0);
    drain_rx();

    addr_ready_i = 0;
    repeat (3) tick();
    chk("R5 stalled without address", addr_valid_o, 0);
    push_addr(7'h2A);
    chk("R5 valid after push", addr_valid_o, 1);
    chk("R6 parity odd-ones address", addr_byte_o, 8'h54);
    tick();
    chk("R5 held while not ready", addr_valid_o, 1);
    chk("R5 byte stable", addr_byte_o, 8'h54);
    addr_ready_i = 1;
    tick(); tick();
    chk("R5 valid dropped", addr_valid_o, 0);
    chk("R7 count one", assigned_o, 1);
    clear_pend();
    chk("R4 cleared", daa_pend_o, 0);

    send_target(8'h10);
    drain_rx();
    push_addr(7'h03);
    tick(); tick();
    chk("R7 count two", assigned_o, 2);
    chk("R6 even-ones address taken", exp_addr_q.size(), 0);
    clear_pend();
    end_run(4'd6, 0);

    push_addr(7'h7F);
    start();
    chk("R7 cleared on start", assigned_o, 0);
    send_target(8'h40);
    tick(); tick();
    chk("R7 preloaded address taken", assigned_o, 1);
    drain_rx();
    clear_pend();
    end_run(4'd4, 0);

    start();
    end_run(4'd1, 1);

    start();
    for (int t = 0; t < 16; t++) begin
      send_target(8'(t * 8));
      drain_rx();
      push_addr(7'(8'h10 + t));
      tick(); tick();
      clear_pend();
    end
    chk("R10 count saturates", assigned_o, 16);
    for (int i = 0; i < 6; i++) send_id(8'hC0 + 8'(i), 0);
    chk("R10 bytes dropped", rx_empty_o, 1);
    chk("R10 no request", daa_pend_o, 0);
    chk("R10 count held", assigned_o, 16);
    end_run(4'd4, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog act=timeout exp=finish");
      end
    join_any
    disable fork;
    chk("R6 all addresses handed off", exp_addr_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule